// File: doc/BRIEF.md
# Floating-point register stack controller

This block keeps the register file and bookkeeping words of a stack-organised floating-point unit. Eight 64-bit slots hold IEEE-754 double values and form a circular stack. A 3-bit top pointer inside the status word selects which physical slot is ST(0). A per-slot valid tag marks which slots hold data. A control word and a status word carry the exception masks, the sticky flags and the condition codes.

The block takes one command per clock cycle. It can push a value, push a copy of ST(i), copy ST(0) into ST(i) with or without a pop, pop, compare ST(0) with ST(1) and pop both (ordered or unordered form), initialise, clear exceptions, or load the control word. The status and control words and the physical tag vector are visible on ports at all times. A combinational read port returns any ST(i) together with its empty tag.

The compare is done in logic on the raw double encodings. Arithmetic units and instruction decode sit outside this block. They feed it through the command port and read operands through the read port.

Top module: `fp_stack_ctrl`

## Requirements
- R1: Reset and the INIT command (op 8) set the control word to 0x037F, clear the whole status word to zero and mark all eight tags empty.
- R2: PUSH (op 1) into a free slot decrements the top pointer (status bits 13:11) modulo 8, writes cmd_data into the new ST(0) and tags that slot valid.
- R3: A push (op 1 or op 2) whose target slot is already valid sets stack fault (bit 6), invalid operation (bit 0) and C1 (bit 9), and leaves contents, tags and top pointer unchanged.
- R4: Reading an empty operand sets stack fault and invalid operation, clears C1, and changes no slot, tag or top pointer. This covers POP, a store with ST(0) empty, a push-copy from an empty ST(i), and a compare with ST(0) or ST(1) empty. A compare fault also sets C3, C2 and C0.
- R5: PUSH_COPY (op 2, index cmd_idx) pushes the value of ST(i), so the old ST(i) becomes ST(i+1).
- R6: STORE (op 3) copies ST(0) into ST(i) and tags it valid, keeping the depth. STORE_POP (op 4) does the same and then pops, so with i = 0 it acts as a pop.
- R7: POP (op 5) tags the top slot empty and increments the top pointer modulo 8.
- R8: COMPARE (op 6) and UCOMPARE (op 7) set {C3 (bit 14), C2 (bit 10), C0 (bit 8)} to 000 for ST(0) > ST(1), 001 for ST(0) < ST(1) and 100 for equality, where +0 equals -0. They clear C1 and pop two entries.
- R9: If either compare operand is a NaN (exponent all ones, fraction non-zero), the codes are 111. COMPARE sets invalid operation for any NaN. UCOMPARE sets it only for a signalling NaN (fraction bit 51 clear).
- R10: CLEAR_EXC (op 9) clears status bits 7:0 and leaves the condition codes, the top pointer, the tags and the contents unchanged.
- R11: LOAD_CW (op 10) loads cw_in into the control word. The exception summary (bit 7) is the OR of status bits 5:0 whose mask bit in the control word is clear.
- R12: rd_data and rd_empty give the value and the empty tag of ST(rd_idx) in the same cycle. Opcodes 0 and 11 to 15 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | A command is presented this cycle |
| cmd_op | input | 4 | Command code |
| cmd_idx | input | 3 | Stack index i for push-copy and store |
| cmd_data | input | 64 | Double value for PUSH |
| cw_in | input | 16 | Control word for LOAD_CW |
| rd_idx | input | 3 | Stack index for the read port |
| rd_data | output | 64 | Value of ST(rd_idx) |
| rd_empty | output | 1 | ST(rd_idx) is empty |
| sts_word | output | 16 | Status word |
| ctl_word | output | 16 | Control word |
| tag_valid | output | 8 | Valid tag per physical slot |

## Verification
A single command can do two things in one cycle, and these cases are where the design can go wrong. STORE_POP with index 0 writes and frees the same slot in one edge, and the pop must win. PUSH_COPY from ST(7) reads the very slot it would write, so it must fault as an overflow instead. The bench drives both shapes directly. Its random phase draws indices 0 and 7 often against full and near-full stacks. After every command a reference model checks every slot through the read port, together with the status word and the tag vector.

// File: rtl/fpstk_pkg.sv
package fpstk_pkg;
  localparam int SLOTS  = 8;
  localparam int PTR_W  = $clog2(SLOTS);
  localparam int VAL_W  = 64;
  localparam int EXP_W  = 11;
  localparam int FRAC_W = 52;
  localparam logic [15:0] CW_DEFAULT = 16'h037F;

  typedef enum logic [3:0] {
    OP_NOP       = 4'd0,
    OP_PUSH      = 4'd1,
    OP_PUSH_COPY = 4'd2,
    OP_STORE     = 4'd3,
    OP_STORE_POP = 4'd4,
    OP_POP       = 4'd5,
    OP_CMP       = 4'd6,
    OP_UCMP      = 4'd7,
    OP_INIT      = 4'd8,
    OP_CLEX      = 4'd9,
    OP_LDCW      = 4'd10
  } stk_op_e;

  function automatic logic fp_is_nan(input logic [VAL_W-1:0] x);
    return (&x[VAL_W-2 -: EXP_W]) && (|x[FRAC_W-1:0]);
  endfunction

  function automatic logic fp_is_snan(input logic [VAL_W-1:0] x);
    return fp_is_nan(x) && !x[FRAC_W-1];
  endfunction

  function automatic logic fp_is_zero(input logic [VAL_W-1:0] x);
    return x[VAL_W-2:0] == '0;
  endfunction

  function automatic logic fp_eq(input logic [VAL_W-1:0] a, input logic [VAL_W-1:0] b);
    return (a == b) || (fp_is_zero(a) && fp_is_zero(b));
  endfunction

  function automatic logic fp_lt(input logic [VAL_W-1:0] a, input logic [VAL_W-1:0] b);
    logic res;
    if (fp_eq(a, b))            res = 1'b0;
    else if (a[VAL_W-1] != b[VAL_W-1]) res = a[VAL_W-1];
    else if (!a[VAL_W-1])       res = a[VAL_W-2:0] < b[VAL_W-2:0];
    else                        res = a[VAL_W-2:0] > b[VAL_W-2:0];
    return res;
  endfunction

  // condition codes {C3, C2, C0}
  function automatic logic [2:0] fp_codes(input logic [VAL_W-1:0] a, input logic [VAL_W-1:0] b);
    logic [2:0] cc;
    if (fp_is_nan(a) || fp_is_nan(b)) cc = 3'b111;
    else if (fp_eq(a, b))             cc = 3'b100;
    else if (fp_lt(a, b))             cc = 3'b001;
    else                              cc = 3'b000;
    return cc;
  endfunction
endpackage

// File: rtl/fpstk_regfile.sv
module fpstk_regfile import fpstk_pkg::*; #(
  parameter int N  = SLOTS,
  parameter int W  = VAL_W,
  localparam int AW = $clog2(N)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] ra_top,
  input  logic [AW-1:0] ra_next,
  input  logic [AW-1:0] ra_src,
  input  logic [AW-1:0] ra_user,
  output logic [W-1:0]  rd_top,
  output logic [W-1:0]  rd_next,
  output logic [W-1:0]  rd_src,
  output logic [W-1:0]  rd_user
);
  logic [W-1:0] mem [N];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rd_top  = mem[ra_top];
  assign rd_next = mem[ra_next];
  assign rd_src  = mem[ra_src];
  assign rd_user = mem[ra_user];
endmodule

// File: rtl/fpstk_cmp.sv
module fpstk_cmp import fpstk_pkg::*; (
  input  logic [VAL_W-1:0] op_a,
  input  logic [VAL_W-1:0] op_b,
  input  logic             quiet_mode,
  output logic [2:0]       codes,
  output logic             invalid
);
  logic any_nan, any_snan;
  assign any_nan  = fp_is_nan(op_a) || fp_is_nan(op_b);
  assign any_snan = fp_is_snan(op_a) || fp_is_snan(op_b);
  assign codes    = fp_codes(op_a, op_b);
  assign invalid  = quiet_mode ? any_snan : any_nan;
endmodule

// File: rtl/fp_stack_ctrl.sv
module fp_stack_ctrl import fpstk_pkg::*; #(
  parameter logic [15:0] CW_INIT = CW_DEFAULT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [3:0]        cmd_op,
  input  logic [PTR_W-1:0]  cmd_idx,
  input  logic [VAL_W-1:0]  cmd_data,
  input  logic [15:0]       cw_in,
  input  logic [PTR_W-1:0]  rd_idx,
  output logic [VAL_W-1:0]  rd_data,
  output logic              rd_empty,
  output logic [15:0]       sts_word,
  output logic [15:0]       ctl_word,
  output logic [SLOTS-1:0]  tag_valid
);
  logic [SLOTS-1:0] tag_q;
  logic [PTR_W-1:0] top_q;
  logic             c3_q, c2_q, c1_q, c0_q, sf_q, ie_q;
  logic [15:0]      cw_q;

  logic [PTR_W-1:0] top_m1, top_p1, top_p2, src_ptr, usr_ptr;
  assign top_m1  = top_q - 1'b1;
  assign top_p1  = top_q + 1'b1;
  assign top_p2  = top_q + 2'd2;
  assign src_ptr = top_q + cmd_idx;
  assign usr_ptr = top_q + rd_idx;

  logic [VAL_W-1:0] v_top, v_next, v_src;
  logic             is_push, is_copy, is_st, is_stp, is_pop, is_cmp;
  assign is_push = cmd_valid && cmd_op == OP_PUSH;
  assign is_copy = cmd_valid && cmd_op == OP_PUSH_COPY;
  assign is_st   = cmd_valid && cmd_op == OP_STORE;
  assign is_stp  = cmd_valid && cmd_op == OP_STORE_POP;
  assign is_pop  = cmd_valid && cmd_op == OP_POP;
  assign is_cmp  = cmd_valid && (cmd_op == OP_CMP || cmd_op == OP_UCMP);

  // named events for the checker
  logic slot_free, ev_push_ok, ev_overflow, ev_underflow, ev_store, ev_pop1, ev_cmp;
  assign slot_free    = !tag_q[top_m1];
  assign ev_push_ok   = (is_push || (is_copy && tag_q[src_ptr])) && slot_free;
  assign ev_overflow  = (is_push || (is_copy && tag_q[src_ptr])) && !slot_free;
  assign ev_underflow = (is_copy && !tag_q[src_ptr])
                     || ((is_st || is_stp || is_pop) && !tag_q[top_q])
                     || (is_cmp && !(tag_q[top_q] && tag_q[top_p1]));
  assign ev_store     = (is_st || is_stp) && tag_q[top_q];
  assign ev_pop1      = (is_stp || is_pop) && tag_q[top_q];
  assign ev_cmp       = is_cmp && tag_q[top_q] && tag_q[top_p1];

  logic             rf_we;
  logic [PTR_W-1:0] rf_waddr;
  logic [VAL_W-1:0] rf_wdata;
  assign rf_we    = ev_push_ok || ev_store;
  assign rf_waddr = ev_store ? src_ptr : top_m1;
  assign rf_wdata = is_push ? cmd_data : (is_copy ? v_src : v_top);

  fpstk_regfile u_rf (
    .clk(clk), .we(rf_we), .waddr(rf_waddr), .wdata(rf_wdata),
    .ra_top(top_q), .ra_next(top_p1), .ra_src(src_ptr), .ra_user(usr_ptr),
    .rd_top(v_top), .rd_next(v_next), .rd_src(v_src), .rd_user(rd_data)
  );

  logic [2:0] cmp_cc;
  logic       cmp_inv;
  fpstk_cmp u_cmp (
    .op_a(v_top), .op_b(v_next), .quiet_mode(cmd_op == OP_UCMP),
    .codes(cmp_cc), .invalid(cmp_inv)
  );

  always_ff @(posedge clk) begin
    if (!rst_n || (cmd_valid && cmd_op == OP_INIT)) begin
      tag_q <= '0; top_q <= '0;
      c3_q <= 1'b0; c2_q <= 1'b0; c1_q <= 1'b0; c0_q <= 1'b0;
      sf_q <= 1'b0; ie_q <= 1'b0; cw_q <= CW_INIT;
    end else if (cmd_valid && cmd_op == OP_CLEX) begin
      sf_q <= 1'b0; ie_q <= 1'b0;
    end else if (cmd_valid && cmd_op == OP_LDCW) begin
      cw_q <= cw_in;
    end else begin
      if (ev_push_ok) begin
        tag_q[top_m1] <= 1'b1;
        top_q         <= top_m1;
      end
      if (ev_store) tag_q[src_ptr] <= 1'b1;
      if (ev_pop1) begin
        tag_q[top_q] <= 1'b0;
        top_q        <= top_p1;
      end
      if (ev_cmp) begin
        tag_q[top_q]  <= 1'b0;
        tag_q[top_p1] <= 1'b0;
        top_q         <= top_p2;
        {c3_q, c2_q, c0_q} <= cmp_cc;
        c1_q <= 1'b0;
        if (cmp_inv) ie_q <= 1'b1;
      end
      if (ev_overflow) begin
        sf_q <= 1'b1; ie_q <= 1'b1; c1_q <= 1'b1;
      end
      if (ev_underflow) begin
        sf_q <= 1'b1; ie_q <= 1'b1; c1_q <= 1'b0;
        if (is_cmp) {c3_q, c2_q, c0_q} <= 3'b111;
      end
    end
  end

  logic [5:0] exc_flags;
  logic       exc_sum;
  assign exc_flags = {5'b0, ie_q};
  assign exc_sum   = |(exc_flags & ~cw_q[5:0]);

  assign sts_word  = {1'b0, c3_q, top_q, c2_q, c1_q, c0_q, exc_sum, sf_q, exc_flags};
  assign ctl_word  = cw_q;
  assign tag_valid = tag_q;
  assign rd_empty  = !tag_q[usr_ptr];
endmodule

// File: rtl/fpstk_checker.sv
module fpstk_checker import fpstk_pkg::*; (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_valid,
  input logic [3:0]       cmd_op,
  input logic [15:0]      sts_word,
  input logic [15:0]      ctl_word,
  input logic [SLOTS-1:0] tag_valid,
  input logic             ev_push_ok,
  input logic             ev_overflow,
  input logic             ev_cmp
);
  assert_init_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == OP_INIT) |=>
      (sts_word == 16'h0 && tag_valid == '0 && ctl_word == CW_DEFAULT));

  assert_push_top_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_push_ok |=> (sts_word[13:11] == $past(sts_word[13:11]) - 3'd1)
                   && ($countones(tag_valid) == $countones($past(tag_valid)) + 1));

  assert_no_overflow_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_overflow |=> (tag_valid == $past(tag_valid)) && $stable(sts_word[13:11])
                    && sts_word[6] && sts_word[0] && sts_word[9]);

  assert_cmp_codes_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_cmp |=> ({sts_word[14], sts_word[10], sts_word[8]} inside {3'b000, 3'b001, 3'b100, 3'b111})
               && ($countones(tag_valid) + 2 == $countones($past(tag_valid))));

  assert_clex_keeps_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == OP_CLEX) |=>
      (sts_word[7:0] == 8'h0) && (sts_word[15:8] == $past(sts_word[15:8])) && $stable(tag_valid));

  assert_masked_summary_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_word[5:0] == 6'h3F) |-> !sts_word[7]);
endmodule

bind fp_stack_ctrl fpstk_checker u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
  .sts_word(sts_word), .ctl_word(ctl_word), .tag_valid(tag_valid),
  .ev_push_ok(ev_push_ok), .ev_overflow(ev_overflow), .ev_cmp(ev_cmp)
);

// File: tb/fp_stack_ctrl_bench.sv
`timescale 1ns/100ps
module fp_stack_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [3:0]  cmd_op = '0;
  logic [2:0]  cmd_idx = '0;
  logic [63:0] cmd_data = '0;
  logic [15:0] cw_in = '0;
  logic [2:0]  rd_idx = '0;
  logic [63:0] rd_data;
  logic        rd_empty;
  logic [15:0] sts_word, ctl_word;
  logic [7:0]  tag_valid;

  always #2.5 clk = ~clk;

  fp_stack_ctrl u_fp_stack_ctrl (.*);

  int n_run = 0, n_fail = 0, cycles = 0;
  bit done = 0;

  // reference model
  logic [63:0] m_reg [8];
  bit          m_tag [8];
  int          m_top;
  bit          m_c3, m_c2, m_c1, m_c0, m_sf, m_ie;
  logic [15:0] m_cw;

  localparam logic [63:0] V_ONE  = 64'h3FF0000000000000;
  localparam logic [63:0] V_TWO  = 64'h4000000000000000;
  localparam logic [63:0] V_M35  = 64'hC00C000000000000;
  localparam logic [63:0] V_PZ   = 64'h0000000000000000;
  localparam logic [63:0] V_NZ   = 64'h8000000000000000;
  localparam logic [63:0] V_QNAN = 64'h7FF8000000000000;
  localparam logic [63:0] V_SNAN = 64'h7FF0000000000001;
  localparam logic [63:0] V_INF  = 64'h7FF0000000000000;

  function automatic bit b_nan(input logic [63:0] x);
    return x[62:52] == 11'h7FF && x[51:0] != 0;
  endfunction

  function automatic logic [15:0] exp_sts();
    bit es;
    es = m_ie && !m_cw[0];
    return {1'b0, m_c3, 3'(m_top), m_c2, m_c1, m_c0, es, m_sf, 5'b0, m_ie};
  endfunction

  task automatic m_fault(input bit c1);
    m_sf = 1; m_ie = 1; m_c1 = c1;
  endtask

  task automatic m_init();
    for (int i = 0; i < 8; i++) m_tag[i] = 0;
    m_top = 0; m_c3 = 0; m_c2 = 0; m_c1 = 0; m_c0 = 0; m_sf = 0; m_ie = 0;
    m_cw = 16'h037F;
  endtask

  task automatic m_step(input int op, input int idx, input logic [63:0] d, input logic [15:0] cwi);
    int tm1, tp1, src;
    logic [63:0] a, b;
    real ra, rb;
    tm1 = (m_top + 7) % 8; tp1 = (m_top + 1) % 8; src = (m_top + idx) % 8;
    case (op)
      1: if (m_tag[tm1]) m_fault(1);
         else begin m_reg[tm1] = d; m_tag[tm1] = 1; m_top = tm1; end
      2: if (!m_tag[src]) m_fault(0);
         else if (m_tag[tm1]) m_fault(1);
         else begin m_reg[tm1] = m_reg[src]; m_tag[tm1] = 1; m_top = tm1; end
      3, 4: if (!m_tag[m_top]) m_fault(0);
            else begin
              m_reg[src] = m_reg[m_top]; m_tag[src] = 1;
              if (op == 4) begin m_tag[m_top] = 0; m_top = tp1; end
            end
      5: if (!m_tag[m_top]) m_fault(0);
         else begin m_tag[m_top] = 0; m_top = tp1; end
      6, 7: if (!m_tag[m_top] || !m_tag[tp1]) begin
              m_fault(0); m_c3 = 1; m_c2 = 1; m_c0 = 1;
            end else begin
              a = m_reg[m_top]; b = m_reg[tp1];
              if (b_nan(a) || b_nan(b)) begin
                m_c3 = 1; m_c2 = 1; m_c0 = 1;
                if (op == 6 || (b_nan(a) && !a[51]) || (b_nan(b) && !b[51])) m_ie = 1;
              end else begin
                ra = $bitstoreal(a); rb = $bitstoreal(b);
                m_c2 = 0;
                m_c3 = (ra == rb);
                m_c0 = (ra < rb);
              end
              m_c1 = 0;
              m_tag[m_top] = 0; m_tag[tp1] = 0; m_top = (m_top + 2) % 8;
            end
      8: m_init();
      9: begin m_sf = 0; m_ie = 0; end
      10: m_cw = cwi;
      default: ;
    endcase
  endtask

  task automatic check_all(input string req);
    bit ok;
    logic [7:0] tv;
    string why;
    ok = 1; why = "";
    n_run++;
    for (int i = 0; i < 8; i++) tv[i] = m_tag[i];
    if (sts_word !== exp_sts()) begin
      ok = 0; $sformat(why, "status act=%h exp=%h", sts_word, exp_sts());
    end else if (ctl_word !== m_cw) begin
      ok = 0; $sformat(why, "control act=%h exp=%h", ctl_word, m_cw);
    end else if (tag_valid !== tv) begin
      ok = 0; $sformat(why, "tags act=%b exp=%b", tag_valid, tv);
    end
    for (int i = 0; i < 8; i++) begin
      int slot;
      slot = (m_top + i) % 8;
      rd_idx = 3'(i);
      #0.2;
      if (ok && rd_empty !== !m_tag[slot]) begin
        ok = 0; $sformat(why, "ST(%0d) empty act=%b exp=%b", i, rd_empty, !m_tag[slot]);
      end else if (ok && m_tag[slot] && rd_data !== m_reg[slot]) begin
        ok = 0; $sformat(why, "ST(%0d) act=%h exp=%h", i, rd_data, m_reg[slot]);
      end
    end
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: %s", req, why);
    end
  endtask

  task automatic do_cmd(input int op, input int idx, input logic [63:0] d,
                        input logic [15:0] cwi, input string req);
    @(negedge clk);
    cmd_valid = 1; cmd_op = 4'(op); cmd_idx = 3'(idx); cmd_data = d; cw_in = cwi;
    @(negedge clk);
    cmd_valid = 0;
    m_step(op, idx, d, cwi);
    check_all(req);
  endtask

  function automatic logic [63:0] pick_val(input int unsigned r);
    case (r % 9)
      0: return V_ONE;  1: return V_TWO;  2: return V_M35;
      3: return V_PZ;   4: return V_NZ;   5: return V_QNAN;
      6: return V_SNAN; 7: return V_INF;
      default: return {$urandom, $urandom};
    endcase
  endfunction

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000 && !done) begin
        n_fail++;
        $display("FAIL watchdog: act=%0d cycles exp=<150000", cycles);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd4242));
    m_init();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check_all("R1 reset");

    // R2 pushes, R5 copy, R6 stores, R7 pop
    do_cmd(1, 0, V_TWO, 0, "R2 push");
    do_cmd(1, 0, V_ONE, 0, "R2 push");
    do_cmd(2, 1, 0, 0, "R5 push copy ST(1)");
    do_cmd(3, 4, 0, 0, "R6 store to ST(4)");
    do_cmd(4, 0, 0, 0, "R6 store-pop idx0");
    do_cmd(4, 2, 0, 0, "R6 store-pop idx2");
    do_cmd(5, 0, 0, 0, "R7 pop");
    do_cmd(0, 3, V_INF, 16'hFFFF, "R12 nop");
    do_cmd(13, 3, V_INF, 16'hFFFF, "R12 unused op");

    // R4 underflow
    do_cmd(8, 0, 0, 0, "R1 init");
    do_cmd(5, 0, 0, 0, "R4 pop empty");
    do_cmd(3, 1, 0, 0, "R4 store empty");
    do_cmd(6, 0, 0, 0, "R4 compare empty");
    do_cmd(9, 0, 0, 0, "R10 clear exc");

    // R3 overflow
    for (int i = 0; i < 8; i++) do_cmd(1, 0, pick_val(i), 0, "R2 fill");
    do_cmd(1, 0, V_ONE, 0, "R3 push full");
    do_cmd(2, 7, 0, 0, "R3 copy ST(7) full");
    do_cmd(2, 3, 0, 0, "R3 copy full");
    do_cmd(10, 0, 0, 16'h037E, "R11 unmask invalid");
    do_cmd(9, 0, 0, 0, "R10 clear with full stack");

    // R8 / R9 compares: push b then a
    do_cmd(8, 0, 0, 0, "R1 init");
    do_cmd(1, 0, V_ONE, 0, "R8 b"); do_cmd(1, 0, V_TWO, 0, "R8 a");
    do_cmd(6, 0, 0, 0, "R8 greater");
    do_cmd(1, 0, V_ONE, 0, "R8 b"); do_cmd(1, 0, V_M35, 0, "R8 a");
    do_cmd(6, 0, 0, 0, "R8 less");
    do_cmd(1, 0, V_PZ, 0, "R8 b"); do_cmd(1, 0, V_NZ, 0, "R8 a");
    do_cmd(7, 0, 0, 0, "R8 zero equal");
    do_cmd(1, 0, V_ONE, 0, "R9 b"); do_cmd(1, 0, V_QNAN, 0, "R9 a");
    do_cmd(7, 0, 0, 0, "R9 unordered quiet nan");
    do_cmd(1, 0, V_SNAN, 0, "R9 b"); do_cmd(1, 0, V_ONE, 0, "R9 a");
    do_cmd(7, 0, 0, 0, "R9 unordered signalling nan");
    do_cmd(9, 0, 0, 0, "R10 clear");
    do_cmd(1, 0, V_QNAN, 0, "R9 b"); do_cmd(1, 0, V_ONE, 0, "R9 a");
    do_cmd(6, 0, 0, 0, "R9 ordered quiet nan");
    do_cmd(10, 0, 0, 16'h0340, "R11 load cw");

    // random phase
    for (int n = 0; n < 3000; n++) begin
      int unsigned r;
      int op, idx;
      r = $urandom % 100;
      if (r < 30) op = 1;
      else if (r < 42) op = 2;
      else if (r < 50) op = 3;
      else if (r < 58) op = 4;
      else if (r < 68) op = 5;
      else if (r < 78) op = 6;
      else if (r < 88) op = 7;
      else if (r < 90) op = 8;
      else if (r < 94) op = 9;
      else if (r < 97) op = 10;
      else op = 11 + ($urandom % 5);
      r = $urandom % 4;
      idx = (r == 0) ? 0 : ((r == 1) ? 7 : int'($urandom % 8));
      do_cmd(op, idx, pick_val($urandom), 16'(16'h0340 | ($urandom % 2)), "R12 random mix");
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule